// File: doc/BRIEF.md
# Edge Interrupt Unit With Lockout

This block turns edges on a port of input pins into a single shared interrupt request. Every pin carries its own enable bit and its own polarity bit. The polarity bit selects whether the pin fires on a rising edge or on a falling edge. The pins are synchronized into the core clock domain, and the synchronized port value is brought out so that software can read it and find out which pin caused the request. There is no priority among the pins.

When a trigger is accepted, the pins that caused it become the lock set. While any pin in the lock set stays at its active level and stays enabled, edges on every other pin are discarded. They are dropped, not queued. The request itself is a pending flag. An acknowledge strobe clears the flag. The acknowledge does not touch the lock set, and it does not touch the enables, which are held outside the block.

Top module: `edge_irq_lockout`

## Requirements
- R1: After reset, irq_o is 0 and port_o is all zeros.
- R2: A pin whose polarity bit is 1 fires on a 0-to-1 change. When the pin changes before clock edge k, irq_o is 0 after edge k+1 and 1 after edge k+2.
- R3: A pin whose polarity bit is 0 fires on a 1-to-0 change only. Its 0-to-1 change raises no request.
- R4: A pin whose enable bit is 0 never raises a request, whatever edges it sees.
- R5: While any locked pin is still at its active level (polarity 1: high, polarity 0: low) and still enabled, edges on all other pins are discarded.
- R6: The lock releases once every locked pin is inactive. After that, new edges are accepted. A pin that went active during the lock does not fire unless it makes a fresh edge.
- R7: Clearing the enable bit of a locked pin removes that pin from the lock set in the same cycle.
- R8: Active edges that are accepted in the same cycle all join the lock set. The lock holds until every one of them is inactive or disabled.
- R9: irq_o stays 1 until ack_i is sampled high. If a new trigger is accepted in the same cycle as ack_i, irq_o stays 1.
- R10: ack_i clears only the pending request. It does not release the lock.
- R11: port_o equals pins_i delayed by the two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_PINS | Asynchronous pin levels |
| enable_i | input | NUM_PINS | Per-pin interrupt enable |
| polarity_i | input | NUM_PINS | Per-pin edge select: 1 rising, 0 falling |
| ack_i | input | 1 | Acknowledge strobe that clears the pending request |
| irq_o | output | 1 | Shared pending interrupt request |
| port_o | output | NUM_PINS | Synchronized pin levels for software readback |

## Verification
The bench builds the block with NUM_PINS = 8 and SYNC_STAGES = 2, so the latency from a pin change to irq_o is a fixed three edges that the directed cases can count exactly. Eight pins give enough room for two pins to fire together while a third edge arrives during the lock. Eight pins also let random enable, polarity and acknowledge traffic collide with locks that are in flight, and the bench compares every cycle against its own cycle model.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam logic POL_RISE = 1'b1;

  // level seen through the polarity: 1 means the pin sits in its trigger state
  function automatic logic active_lvl(input logic lvl, input logic pol);
    return (pol == POL_RISE) ? lvl : ~lvl;
  endfunction
endpackage

// File: rtl/pin_sync_bank.sv
module pin_sync_bank #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= async_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/edge_qualify.sv
module edge_qualify
  import edge_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] polarity_i,
  input  logic [W-1:0] enable_i,
  output logic [W-1:0] armed_o,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic act_now, act_prev;
    assign act_now    = active_lvl(level_i[i], polarity_i[i]);
    assign act_prev   = active_lvl(prev_q[i], polarity_i[i]);
    assign armed_o[i] = act_now & enable_i[i];
    assign edge_o[i]  = act_now & ~act_prev & enable_i[i];
  end
endmodule

// File: rtl/lockout_ctrl.sv
module lockout_ctrl #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] armed_i,
  input  logic         ack_i,
  output logic         accept_o,
  output logic [W-1:0] lock_o,
  output logic         irq_o
);
  logic [W-1:0] lock_q;
  logic         pend_q;
  logic         hold;

  // lock persists only while some locked pin is still armed
  assign hold     = |(lock_q & armed_i);
  assign accept_o = ~hold & (|edge_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      pend_q <= 1'b0;
    end else if (accept_o) begin
      lock_q <= edge_i;
      pend_q <= 1'b1;
    end else begin
      lock_q <= lock_q & armed_i;
      if (ack_i) pend_q <= 1'b0;
    end
  end

  assign lock_o = lock_q;
  assign irq_o  = pend_q;
endmodule

// File: rtl/edge_irq_lockout.sv
module edge_irq_lockout #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic [NUM_PINS-1:0] enable_i,
  input  logic [NUM_PINS-1:0] polarity_i,
  input  logic                ack_i,
  output logic                irq_o,
  output logic [NUM_PINS-1:0] port_o
);
  logic [NUM_PINS-1:0] level;
  logic [NUM_PINS-1:0] armed;
  logic [NUM_PINS-1:0] edges;
  logic [NUM_PINS-1:0] lock_mask;
  logic                accept;

  pin_sync_bank #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pins_i),
    .sync_o  (level)
  );

  edge_qualify #(.W(NUM_PINS)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .level_i    (level),
    .polarity_i (polarity_i),
    .enable_i   (enable_i),
    .armed_o    (armed),
    .edge_o     (edges)
  );

  lockout_ctrl #(.W(NUM_PINS)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .edge_i   (edges),
    .armed_i  (armed),
    .ack_i    (ack_i),
    .accept_o (accept),
    .lock_o   (lock_mask),
    .irq_o    (irq_o)
  );

  assign port_o = level;
endmodule

// File: rtl/edge_irq_lockout_chk.sv
module edge_irq_lockout_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ack_i,
  input logic [W-1:0] enable_i,
  input logic         irq_o,
  input logic         accept_i,
  input logic [W-1:0] lock_i
);
  assert_ack_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !accept_i) |=> !irq_o);

  assert_irq_rise_from_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(accept_i));

  assert_lock_no_gain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> ((lock_i & ~$past(lock_i)) == '0));

  assert_accept_locks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (irq_o && (lock_i != '0)));

  assert_lock_enabled_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> ((lock_i & ~$past(enable_i)) == '0));
endmodule

bind edge_irq_lockout edge_irq_lockout_chk #(.W(NUM_PINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ack_i    (ack_i),
  .enable_i (enable_i),
  .irq_o    (irq_o),
  .accept_i (accept),
  .lock_i   (lock_mask)
);

// File: tb/edge_irq_lockout_tb.sv
module edge_irq_lockout_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic [N-1:0] en = '0;
  logic [N-1:0] pol = '0;
  logic         ack = 1'b0;
  logic         irq;
  logic [N-1:0] port;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_irq_lockout #(.NUM_PINS(N), .SYNC_STAGES(2)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pins_i     (pins),
    .enable_i   (en),
    .polarity_i (pol),
    .ack_i      (ack),
    .irq_o      (irq),
    .port_o     (port)
  );

  // cycle model built from the requirements
  logic [N-1:0] ms1, ms2, mp, mlock;
  logic         mpend;

  function automatic logic [N-1:0] f_act(input logic [N-1:0] lv, input logic [N-1:0] pl);
    return (pl & lv) | (~pl & ~lv);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms1 <= '0; ms2 <= '0; mp <= '0; mlock <= '0; mpend <= 1'b0;
    end else begin
      logic [N-1:0] armed, q;
      armed = f_act(ms2, pol) & en;
      q     = armed & ~f_act(mp, pol);
      if (((mlock & armed) == '0) && (q != '0)) begin
        mlock <= q;
        mpend <= 1'b1;
      end else begin
        mlock <= mlock & armed;
        if (ack) mpend <= 1'b0;
      end
      ms1 <= pins; ms2 <= ms1; mp <= ms2;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    en = '0; pol = '0; pins = '0; ack = 1'b0;
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(3);
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    rst_n = 1'b0;
    cyc(1);
    chk("R1 irq", irq, 0);
    chk("R1 port", port, 0);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 irq after release", irq, 0);

    // R2 rising edge with latency
    do_reset();
    en = 8'h01; pol = 8'h01; pins = 8'h01;
    cyc(2);
    chk("R2 not yet", irq, 0);
    chk("R11 port", port, 8'h01);
    cyc(1);
    chk("R2 raised", irq, 1);
    cyc(10);
    chk("R9 held without ack", irq, 1);
    ack_pulse();
    chk("R9 cleared by ack", irq, 0);

    // R9 ack in the same cycle as a new accept
    do_reset();
    en = 8'h01; pol = 8'h01; pins = 8'h01;
    cyc(2);
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    chk("R9 accept beats ack", irq, 1);

    // R3 falling polarity
    do_reset();
    en = 8'h08; pol = 8'h00; pins = 8'h08;
    cyc(5);
    chk("R3 rise ignored", irq, 0);
    pins = 8'h00;
    cyc(3);
    chk("R3 fall fires", irq, 1);

    // R4 disabled pins
    do_reset();
    en = 8'h00; pol = 8'hff; pins = 8'hff;
    cyc(5);
    chk("R4 disabled rise", irq, 0);
    pins = 8'h00;
    cyc(5);
    chk("R4 disabled fall", irq, 0);
    en = 8'hff;
    cyc(5);
    chk("R4 enable without edge", irq, 0);

    // R5, R10, R6 lockout and release by inactive level
    do_reset();
    en = 8'h03; pol = 8'h03; pins = 8'h01;
    cyc(3);
    chk("R5 first trigger", irq, 1);
    ack_pulse();
    pins = 8'h03;
    cyc(5);
    chk("R10 ack keeps lock", irq, 0);
    pins = 8'h02;
    cyc(5);
    chk("R6 no retrigger of held pin", irq, 0);
    pins = 8'h00;
    cyc(3);
    pins = 8'h02;
    cyc(3);
    chk("R6 fresh edge after release", irq, 1);

    // R7 release by disabling the locked pin
    do_reset();
    en = 8'h03; pol = 8'h03; pins = 8'h01;
    cyc(3);
    ack_pulse();
    pins = 8'h03;
    cyc(4);
    chk("R5 blocked", irq, 0);
    en = 8'h02;
    cyc(2);
    chk("R7 no spurious", irq, 0);
    pins = 8'h01;
    cyc(3);
    pins = 8'h03;
    cyc(3);
    chk("R7 edge after disable release", irq, 1);

    // R8 simultaneous edges
    do_reset();
    en = 8'hff; pol = 8'hff; pins = 8'h60;
    cyc(3);
    chk("R8 pair fires", irq, 1);
    ack_pulse();
    pins = 8'h40;
    cyc(3);
    pins = 8'hc0;
    cyc(4);
    chk("R8 second of pair holds lock", irq, 0);
    pins = 8'h80;
    cyc(4);
    chk("R8 no retrigger", irq, 0);
    pins = 8'h00;
    cyc(3);
    pins = 8'h80;
    cyc(3);
    chk("R8 released", irq, 1);

    // random traffic against the model
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) pins = pins ^ (8'h01 << $urandom_range(N - 1));
      if ($urandom_range(31) == 0) en = en ^ (8'h01 << $urandom_range(N - 1));
      if ($urandom_range(63) == 0) pol = pol ^ (8'h01 << $urandom_range(N - 1));
      ack = ($urandom_range(7) == 0);
      cyc(1);
      chk("R5 random irq", irq, mpend);
      chk("R11 random port", port, ms2);
    end
    ack = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule